// File: doc/BRIEF.md
# Row-Buffered DRAM Access Controller

This block pairs a small behavioural DRAM array with the controller that drives it. A requester hands over a linear cell number, a read or write flag and a data byte. The controller splits the cell number into a row index and a column index and sends them one after the other over a narrow shared address bus. A row strobe copies the addressed row into an internal row buffer. A column strobe then picks one cell out of that buffer, either returning it as read data or overwriting it. Completion is signalled by a single-cycle done pulse.

The controller remembers which row is held in the buffer. A later access to that same row skips the row phase and finishes sooner. A buffer changed by writes is copied back to the array before any other row is loaded. A free-running timer raises a refresh demand at a fixed interval. That demand is served ahead of waiting requests: it loads the next row in rotation and then closes the buffer. The DRAM-side strobes and the address bus come out as ports, so a system can watch the array traffic.

Top module: `rbd_dram_ctrl`

## Requirements
- R1: In the cycle after a synchronous reset, done, busy and all four DRAM-side strobes are low.
- R2: Cell number n (0 to 15) is served at row n/4 and column n mod 4. The row index is on mem_addr while mem_row_stb is high and mem_refresh is low. The column index is on mem_addr while mem_col_stb is high. Cell 9 therefore uses row 2, column 1.
- R3: A read returns the byte most recently written to the same cell. rd_data is valid in the cycle where done is high.
- R4: Writes change only the row buffer. A modified buffer is written back to the array (mem_wb_stb) before another row is opened or a refresh runs, so data survives a change of row.
- R5: Counting clock edges from the first edge at which req_valid is sampled high to the edge that raises done, the latency is 2 when the row is already open, 3 when a different row is opened from a clean buffer, and 4 when the buffer must first be written back.
- R6: After reset no row is open, so the first access always performs a row phase.
- R7: A request is taken only while idle. Address, data and write flag are captured at acceptance, and later changes to them do not affect the transaction in flight. done is high for exactly one cycle.
- R8: A refresh demand arises every REFRESH_INTERVAL cycles and wins over a request waiting in idle. Its row strobe (mem_refresh high) walks the rows 0,1,2,3,0 in order. While idle, consecutive refreshes are exactly REFRESH_INTERVAL cycles apart.
- R9: A refresh closes the open row, so the next access always performs a row phase. Data written before the refresh is still returned afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; hold until done |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Linear cell number |
| req_wdata | input | 8 | Write byte |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Controller not idle |
| rd_data | output | 8 | Read byte, valid with done |
| mem_row_stb | output | 1 | Row strobe (access or refresh) |
| mem_col_stb | output | 1 | Column strobe |
| mem_wb_stb | output | 1 | Row buffer write-back strobe |
| mem_refresh | output | 1 | Current row strobe is a refresh |
| mem_addr | output | 2 | Multiplexed row/column address bus |

## Verification
The bench walks a sequence that mixes row hits, misses over a clean buffer and misses over a dirty buffer, and measures each latency. A controller that never reuses the open row shows 3 where 2 is expected. One that skips the write-back loses a byte when the row is revisited. A refresh demand is arranged to arrive in the same cycle as a request. A design that lets the request win finishes in 3 cycles instead of 5, and one that leaves the row open after a refresh shows no row phase. Changing the address in mid-flight, resetting during a transaction and starting the first access after reset check that requests are captured once and that the open-row state starts invalid.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_WB,
    ST_REF
  } rbd_state_e;

  function automatic int rbd_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rbd_array.sv
module rbd_array #(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int DATA_W = 8,
  parameter int BUS_W  = 2
) (
  input  logic              clk,
  input  logic              row_stb,
  input  logic              col_stb,
  input  logic              col_we,
  input  logic              wb_stb,
  input  logic [BUS_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);

  // storage rows, no reset so a block RAM can be inferred
  logic [COLS-1:0][DATA_W-1:0] cells [ROWS];
  logic [COLS-1:0][DATA_W-1:0] row_buf;

  always_ff @(posedge clk) begin
    if (wb_stb) cells[bus_addr[ROW_W-1:0]] <= row_buf;
  end

  always_ff @(posedge clk) begin
    if (row_stb) begin
      row_buf <= cells[bus_addr[ROW_W-1:0]];
    end else if (col_stb && col_we) begin
      row_buf[bus_addr[COL_W-1:0]] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (col_stb && !col_we) rdata <= row_buf[bus_addr[COL_W-1:0]];
  end
endmodule

// File: rtl/rbd_refresh_timer.sv
module rbd_refresh_timer #(
  parameter int INTERVAL = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  output logic pending
);
  localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
      if (cnt == LAST) pending <= 1'b1;
      else if (ack)    pending <= 1'b0;
    end
  end
endmodule

// File: rtl/rbd_seq.sv
module rbd_seq
  import rbd_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int DATA_W = 8,
  parameter int BUS_W  = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           req_valid,
  input  logic                           req_write,
  input  logic [$clog2(ROWS*COLS)-1:0]   req_addr,
  input  logic [DATA_W-1:0]              req_wdata,
  input  logic                           ref_pend,
  output logic                           ref_ack,
  output logic                           busy,
  output logic                           done,
  output logic                           row_stb,
  output logic                           col_stb,
  output logic                           col_we,
  output logic                           wb_stb,
  output logic                           refresh,
  output logic [BUS_W-1:0]               bus_addr,
  output logic [DATA_W-1:0]              wdata
);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int COL_W  = $clog2(COLS);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  rbd_state_e        state;
  logic [ROW_W-1:0]  open_row, cur_row, ref_row;
  logic [COL_W-1:0]  cur_col;
  logic              open_vld, dirty, cur_wr, wb_to_ref;
  logic [ROW_W-1:0]  in_row;
  logic [COL_W-1:0]  in_col;

  assign in_row = req_addr[ADDR_W-1:COL_W];
  assign in_col = req_addr[COL_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      open_row  <= '0;
      open_vld  <= 1'b0;
      dirty     <= 1'b0;
      ref_row   <= '0;
      cur_row   <= '0;
      cur_col   <= '0;
      cur_wr    <= 1'b0;
      wdata     <= '0;
      wb_to_ref <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (ref_pend) begin
            wb_to_ref <= 1'b1;
            state     <= dirty ? ST_WB : ST_REF;
          end else if (req_valid) begin
            cur_row   <= in_row;
            cur_col   <= in_col;
            cur_wr    <= req_write;
            wdata     <= req_wdata;
            wb_to_ref <= 1'b0;
            if (open_vld && (in_row == open_row)) state <= ST_COL;
            else if (dirty)                       state <= ST_WB;
            else                                  state <= ST_ROW;
          end
        end
        ST_ROW: begin
          open_row <= cur_row;
          open_vld <= 1'b1;
          state    <= ST_COL;
        end
        ST_COL: begin
          if (cur_wr) dirty <= 1'b1;
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        ST_WB: begin
          dirty <= 1'b0;
          state <= wb_to_ref ? ST_REF : ST_ROW;
        end
        ST_REF: begin
          open_vld <= 1'b0;
          ref_row  <= (ref_row == LAST_ROW) ? '0 : ref_row + 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_ROW:  bus_addr = BUS_W'(cur_row);
      ST_COL:  bus_addr = BUS_W'(cur_col);
      ST_WB:   bus_addr = BUS_W'(open_row);
      ST_REF:  bus_addr = BUS_W'(ref_row);
      default: bus_addr = '0;
    endcase
  end

  assign busy    = (state != ST_IDLE);
  assign row_stb = (state == ST_ROW) || (state == ST_REF);
  assign col_stb = (state == ST_COL);
  assign col_we  = (state == ST_COL) && cur_wr;
  assign wb_stb  = (state == ST_WB);
  assign refresh = (state == ST_REF);
  assign ref_ack = (state == ST_REF);
endmodule

// File: rtl/rbd_dram_ctrl.sv
module rbd_dram_ctrl #(
  parameter int ROWS             = 4,
  parameter int COLS             = 4,
  parameter int DATA_W           = 8,
  parameter int REFRESH_INTERVAL = 512
) (
  input  logic                                                 clk,
  input  logic                                                 rst,
  input  logic                                                 req_valid,
  input  logic                                                 req_write,
  input  logic [$clog2(ROWS*COLS)-1:0]                         req_addr,
  input  logic [DATA_W-1:0]                                    req_wdata,
  output logic                                                 done,
  output logic                                                 busy,
  output logic [DATA_W-1:0]                                    rd_data,
  output logic                                                 mem_row_stb,
  output logic                                                 mem_col_stb,
  output logic                                                 mem_wb_stb,
  output logic                                                 mem_refresh,
  output logic [rbd_pkg::rbd_max($clog2(ROWS), $clog2(COLS))-1:0] mem_addr
);
  localparam int BUS_W = rbd_pkg::rbd_max($clog2(ROWS), $clog2(COLS));

  logic              ref_pend, ref_ack, arr_col_we;
  logic [DATA_W-1:0] arr_wdata;

  rbd_refresh_timer #(.INTERVAL(REFRESH_INTERVAL)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .ack     (ref_ack),
    .pending (ref_pend)
  );

  rbd_seq #(.ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W), .BUS_W(BUS_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ref_pend  (ref_pend),
    .ref_ack   (ref_ack),
    .busy      (busy),
    .done      (done),
    .row_stb   (mem_row_stb),
    .col_stb   (mem_col_stb),
    .col_we    (arr_col_we),
    .wb_stb    (mem_wb_stb),
    .refresh   (mem_refresh),
    .bus_addr  (mem_addr),
    .wdata     (arr_wdata)
  );

  rbd_array #(.ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W), .BUS_W(BUS_W)) u_array (
    .clk      (clk),
    .row_stb  (mem_row_stb),
    .col_stb  (mem_col_stb),
    .col_we   (arr_col_we),
    .wb_stb   (mem_wb_stb),
    .bus_addr (mem_addr),
    .wdata    (arr_wdata),
    .rdata    (rd_data)
  );
endmodule

// File: rtl/rbd_checker.sv
module rbd_checker #(
  parameter int ROWS     = 4,
  parameter int INTERVAL = 512,
  parameter int BUS_W    = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             done,
  input logic             mem_row_stb,
  input logic             mem_col_stb,
  input logic             mem_wb_stb,
  input logic             mem_refresh,
  input logic [BUS_W-1:0] mem_addr,
  input logic             col_we
);
  localparam int ROW_W = $clog2(ROWS);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  logic             chk_dirty, chk_opened;
  logic [ROW_W-1:0] exp_ref;
  logic [31:0]      gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_dirty  <= 1'b0;
      chk_opened <= 1'b0;
      exp_ref    <= '0;
      gap        <= '0;
    end else begin
      if (mem_col_stb && col_we) chk_dirty <= 1'b1;
      else if (mem_wb_stb)       chk_dirty <= 1'b0;
      if (mem_refresh)      chk_opened <= 1'b0;
      else if (mem_row_stb) chk_opened <= 1'b1;
      if (mem_refresh) begin
        exp_ref <= (exp_ref == LAST_ROW) ? '0 : exp_ref + 1'b1;
        gap     <= '0;
      end else begin
        gap <= gap + 1;
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_DONE_AFTER_COL: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(mem_col_stb)); // R3
  AST_WB_BEFORE_OPEN: assert property (@(posedge clk) disable iff (rst)
    mem_row_stb |-> !chk_dirty); // R4
  AST_COL_NEEDS_ROW: assert property (@(posedge clk) disable iff (rst)
    mem_col_stb |-> chk_opened); // R6
  AST_REFRESH_ORDER: assert property (@(posedge clk) disable iff (rst)
    mem_refresh |-> (mem_addr == BUS_W'(exp_ref))); // R8
  AST_REFRESH_BOUND: assert property (@(posedge clk) disable iff (rst)
    gap <= 32'(INTERVAL + 6)); // R8
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_row_stb, mem_col_stb, mem_wb_stb})); // R2
endmodule

bind rbd_dram_ctrl rbd_checker #(
  .ROWS(ROWS), .INTERVAL(REFRESH_INTERVAL), .BUS_W(BUS_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .done        (done),
  .mem_row_stb (mem_row_stb),
  .mem_col_stb (mem_col_stb),
  .mem_wb_stb  (mem_wb_stb),
  .mem_refresh (mem_refresh),
  .mem_addr    (mem_addr),
  .col_we      (arr_col_we)
);

// File: tb/rbd_dram_ctrl_bench.sv
`timescale 1ns/1ps
module rbd_dram_ctrl_bench;
  localparam int RI = 300;
  localparam int NV = 15;
  // {write, cell, data (write value or expected read), latency}
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 4'd0,  8'h11, 4'd3},
    {1'b1, 4'd1,  8'h22, 4'd2},
    {1'b1, 4'd9,  8'h99, 4'd4},
    {1'b1, 4'd10, 8'hAA, 4'd2},
    {1'b0, 4'd0,  8'h11, 4'd4},
    {1'b0, 4'd1,  8'h22, 4'd2},
    {1'b1, 4'd15, 8'hF5, 4'd3},
    {1'b0, 4'd9,  8'h99, 4'd4},
    {1'b0, 4'd10, 8'hAA, 4'd2},
    {1'b0, 4'd15, 8'hF5, 4'd3},
    {1'b1, 4'd4,  8'h44, 4'd3},
    {1'b1, 4'd4,  8'h45, 4'd2},
    {1'b0, 4'd4,  8'h45, 4'd2},
    {1'b0, 4'd0,  8'h11, 4'd4},
    {1'b0, 4'd4,  8'h45, 4'd3}
  };

  logic       clk = 1'b0, rst = 1'b1;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [3:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       done, busy, mem_row_stb, mem_col_stb, mem_wb_stb, mem_refresh;
  logic [7:0] rd_data;
  logic [1:0] mem_addr;

  int checks = 0, failures = 0;
  int t_lat, cyc = 0;
  bit t_row, t_col, t_ref;
  logic [1:0] t_rowa, t_cola;
  logic [7:0] t_rd;

  always #4 clk = ~clk;
  always @(negedge clk) cyc++;

  rbd_dram_ctrl #(.REFRESH_INTERVAL(RI)) u_rbd_dram_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .busy(busy),
    .rd_data(rd_data), .mem_row_stb(mem_row_stb), .mem_col_stb(mem_col_stb),
    .mem_wb_stb(mem_wb_stb), .mem_refresh(mem_refresh), .mem_addr(mem_addr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_txn(input logic wr, input logic [3:0] a, input logic [7:0] d,
                         input bit scramble);
    bit fin = 0;
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    t_lat = 0; t_row = 0; t_col = 0; t_ref = 0; t_rowa = '0; t_cola = '0;
    while (!fin) begin
      @(posedge clk);
      t_lat++;
      @(negedge clk);
      if (scramble) begin req_addr = ~a; req_wdata = ~d; req_write = ~wr; end
      if (mem_refresh) t_ref = 1;
      else if (mem_row_stb) begin t_row = 1; t_rowa = mem_addr; end
      if (mem_col_stb) begin t_col = 1; t_cola = mem_addr; end
      if (done || t_lat > 20) fin = 1;
    end
    t_rd = rd_data;
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int rcyc [5];
    logic [1:0] raddr [5];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!done && !busy, "R1 done/busy", {done, busy}, 0);
    chk(!mem_row_stb && !mem_col_stb && !mem_wb_stb && !mem_refresh, "R1 strobes",
        {mem_row_stb, mem_col_stb, mem_wb_stb, mem_refresh}, 0);

    // vector walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      logic wr; logic [3:0] a; logic [7:0] d; logic [3:0] lat;
      {wr, a, d, lat} = VEC[i];
      run_txn(wr, a, d, 0);
      if (i == 0) chk(t_row, "R6 first access opens row", t_row, 1);
      if (!t_ref) chk(t_lat == int'(lat), "R5 latency", t_lat, lat);
      chk(t_col && t_cola == a[1:0], "R2 column index", t_cola, a[1:0]);
      if (t_row) chk(t_rowa == a[3:2], "R2 row index", t_rowa, a[3:2]);
      if (!wr) chk(t_rd == d, "R3 R4 read data", t_rd, d);
      @(negedge clk);
      chk(!done, "R7 done single cycle", done, 0);
    end
    // R2 cell 9 maps to row 2 column 1
    run_txn(1'b0, 4'd9, 8'h00, 0);
    chk(t_rowa == 2'd2 && t_cola == 2'd1, "R2 cell 9 -> (2,1)", {t_rowa, t_cola}, 4'h9);
    run_txn(1'b1, 4'd6, 8'h66, 0);   // leaves row 1 modified

    // R8 refresh order and spacing
    for (int k = 0; k < 5; k++) begin
      int guard = 0;
      do begin @(negedge clk); guard++; end while (!mem_refresh && guard < 2000);
      rcyc[k] = cyc; raddr[k] = mem_addr;
      chk(raddr[k] == 2'(k % 4), "R8 refresh row order", raddr[k], k % 4);
      if (k >= 2) chk(rcyc[k] - rcyc[k-1] == RI, "R8 refresh interval",
                      rcyc[k] - rcyc[k-1], RI);
    end

    // R8 refresh beats a simultaneous request; R9 row closed, data kept
    repeat (RI - 1) @(negedge clk);
    run_txn(1'b0, 4'd6, 8'h00, 0);
    chk(t_ref, "R8 refresh served first", t_ref, 1);
    chk(t_lat == 5, "R8 R9 latency after refresh", t_lat, 5);
    chk(t_row, "R9 row reopened after refresh", t_row, 1);
    chk(t_rd == 8'h66, "R9 data survives refresh", t_rd, 8'h66);
    run_txn(1'b0, 4'd6, 8'h00, 0);
    chk(t_lat == 2, "R5 hit after refresh", t_lat, 2);

    // R7 inputs changed mid-flight are ignored
    run_txn(1'b0, 4'd9, 8'h00, 1);
    chk(t_rd == 8'h99, "R7 captured address", t_rd, 8'h99);
    chk(t_rowa == 2'd2 && t_lat == 3, "R7 captured row/latency", {t_rowa, 4'(t_lat)}, 6'h23);
    run_txn(1'b0, 4'd9, 8'h00, 0);
    chk(t_rd == 8'h99, "R7 no stray write", t_rd, 8'h99);

    // R1 R6 reset during a transaction
    req_write = 1'b0; req_addr = 4'd9; req_valid = 1'b1;
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done, "R1 reset mid-transaction", {busy, done}, 0);
    run_txn(1'b0, 4'd9, 8'h00, 0);
    chk(t_row && t_lat == 3, "R6 row phase after reset", {t_row, 4'(t_lat)}, 5'h13);
    chk(t_rd == 8'h99, "R3 read after reset", t_rd, 8'h99);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule